// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Controller

This block turns single read and write requests, presented on a simple valid/ready request port, into asynchronous cycles on an external static-memory bus. The bus serves SRAM, PSRAM or NOR devices. Every device shares the address lines, the data lines and the strobes. Each device has its own active-low chip select. Only one external access runs at a time. While an access or its turnaround is in progress the request port reports not ready.

Each chip select has its own timing, given in internal clock cycles. The timing covers byte-lane setup, address setup, address hold, data setup, data hold and bus turnaround. Writes may take a second timing set instead of the read set. Per chip select, the device can be 8 or 16 bits wide. Address and data can share the data lines, with the address driven during the address phases. An external wait input, with programmable polarity, can stretch the data setup phase. The response port returns one pulse per request when the data phase ends, and for a read it carries the read data with that pulse.

Top module: `static_mem_ctrl`

## Requirements
- R1: After reset all chip selects, output enable and write enable are high, both byte-lane enables are high, the data bus is not driven, req_ready is 1 and rsp_valid is 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. From the cycle after acceptance, req_ready stays 0 until the access and its turnaround have ended. At most one chip select is low at any time, and it is the one whose index was given in req_cs.
- R3: After acceptance the byte-lane enables go low for the chip select's byte-lane setup count of cycles while every chip select is still high. A count of 0 skips this phase. The byte-lane enables stay low until the data phase ends. With a 16-bit device they equal the inverted req_be; with an 8-bit device they are 2'b10, so only lane 0 (bit 0) is enabled.
- R4: The address setup phase lasts max(address setup, 1) cycles. In it the chip select is low and both strobes are high. With multiplexing on, an address hold phase of exactly the address hold count of cycles follows, and the data lines carry address bits [15:0] during both phases. With multiplexing off, the address hold count has no effect.
- R5: The data setup phase lasts max(data setup, 1) cycles. Output enable is low in it for a read, and write enable is low in it for a write; the two are never low together. During a write the data lines carry req_wdata for a 16-bit device, or {8'h00, req_wdata[7:0]} for an 8-bit device.
- R6: The data hold phase lasts the data hold count of cycles, and a count of 0 skips it. In it both strobes are high and the chip select stays low. Write data is still driven.
- R7: rsp_valid is 1 for exactly one cycle per request: the cycle after the last data setup or data hold cycle. For a read, rsp_rdata holds the data lines as sampled on the last data setup cycle; for an 8-bit device its upper byte is zero.
- R8: After the response cycle begins, req_ready stays 0 for the turnaround count of cycles. With a count of 0, req_ready is 1 already in the response cycle.
- R9: A write to a chip select whose separate-write flag is set uses the write timing vector for address setup, address hold, data setup, data hold and turnaround. Reads, and writes with the flag clear, use the read timing vector.
- R10: With wait enabled, the data setup phase does not end while mem_wait sits at its active level. The active level is 1 when the wait-polarity flag is set and 0 otherwise. With wait disabled, mem_wait has no effect on the timing.
- R11: For chip select i, timing vector slice [i*5*TW +: 5*TW] holds five TW-bit fields, starting from the LSB: address setup, address hold, data setup, data hold, turnaround. cfg_bls slice [i*TW +: TW] is the byte-lane setup count. cfg_flags slice [i*5 +: 5] holds, by bit: bit0 16-bit width, bit1 multiplexing, bit2 wait enable, bit3 wait active high, bit4 separate write timing.
- R12: The data bus is never driven while output enable is low. During a read it is driven only in multiplexed address phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 for write, 0 for read |
| req_cs | input | CSW | Target chip select index |
| req_addr | input | AW | Address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lanes for a 16-bit device |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data |
| cfg_rd_tim | input | NCS*5*TW | Read (primary) timing per chip select |
| cfg_wr_tim | input | NCS*5*TW | Write timing per chip select |
| cfg_bls | input | NCS*TW | Byte-lane setup count per chip select |
| cfg_flags | input | NCS*5 | Mode flags per chip select |
| mem_addr | output | AW | External address |
| mem_cs_n | output | NCS | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_be_n | output | 2 | Active-low byte-lane enables |
| mem_dq_out | output | 16 | Data lines driven value |
| mem_dq_oe | output | 1 | Data lines drive enable |
| mem_dq_in | input | 16 | Data lines sampled value |
| mem_wait | input | 1 | External wait |

## Verification
A corrupted phase counter or state shows up on the bus within a cycle or two. A strobe that is too long or too short, a chip select that releases early, or a response that comes one cycle off all appear as soon as the phase in question ends. A wrong capture point gives a wrong read value in the response cycle. A turnaround error appears as req_ready rising in the wrong cycle. Each cycle of every access is compared against a timeline built from that chip select's configuration, so the first wrong cycle is the one reported.

// File: rtl/static_mem_ctrl.sv
module static_mem_ctrl #(
  parameter int NCS = 2,
  parameter int AW  = 20,
  parameter int TW  = 4,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int TSW = 5 * TW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CSW-1:0]    req_cs,
  input  logic [AW-1:0]     req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  input  logic [NCS*TSW-1:0] cfg_rd_tim,
  input  logic [NCS*TSW-1:0] cfg_wr_tim,
  input  logic [NCS*TW-1:0] cfg_bls,
  input  logic [NCS*5-1:0]  cfg_flags,
  output logic [AW-1:0]     mem_addr,
  output logic [NCS-1:0]    mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [1:0]        mem_be_n,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in,
  input  logic              mem_wait
);

  typedef enum logic [2:0] {S_IDLE, S_BLS, S_ADDR, S_AHLD, S_DSET, S_DHLD, S_TURN} st_t;

  st_t            st;
  logic [TW-1:0]  cnt;
  logic           wr_q;
  logic [CSW-1:0] cs_q;
  logic [AW-1:0]  addr_q;
  logic [15:0]    wd_q;
  logic [1:0]     be_q;

  function automatic logic [TW-1:0] min1(input logic [TW-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  wire            idle   = (st == S_IDLE);
  wire [CSW-1:0]  sel_cs = idle ? req_cs : cs_q;
  wire            sel_wr = idle ? req_write : wr_q;
  wire [4:0]      fl     = cfg_flags[int'(sel_cs)*5 +: 5];
  wire [TW-1:0]   t_bls  = cfg_bls[int'(sel_cs)*TW +: TW];
  wire [TSW-1:0]  tim    = (sel_wr && fl[4]) ? cfg_wr_tim[int'(sel_cs)*TSW +: TSW]
                                             : cfg_rd_tim[int'(sel_cs)*TSW +: TSW];
  wire [TW-1:0]   t_as   = tim[0*TW +: TW];
  wire [TW-1:0]   t_ah   = tim[1*TW +: TW];
  wire [TW-1:0]   t_ds   = tim[2*TW +: TW];
  wire [TW-1:0]   t_dh   = tim[3*TW +: TW];
  wire [TW-1:0]   t_ta   = tim[4*TW +: TW];
  wire            wait_act = fl[2] && (mem_wait == fl[3]);

  st_t           fin_st;
  logic [TW-1:0] fin_cnt;
  always_comb begin
    fin_st  = (t_ta != '0) ? S_TURN : S_IDLE;
    fin_cnt = t_ta - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      cs_q      <= '0;
      addr_q    <= '0;
      wd_q      <= '0;
      be_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          wr_q   <= req_write;
          cs_q   <= req_cs;
          addr_q <= req_addr;
          wd_q   <= req_wdata;
          be_q   <= req_be;
          if (t_bls != '0) begin st <= S_BLS;  cnt <= t_bls - 1'b1; end
          else             begin st <= S_ADDR; cnt <= min1(t_as);   end
        end
        S_BLS:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin st <= S_ADDR; cnt <= min1(t_as); end
        S_ADDR:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (fl[1] && t_ah != '0) begin st <= S_AHLD; cnt <= t_ah - 1'b1; end
          else begin st <= S_DSET; cnt <= min1(t_ds); end
        S_AHLD:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin st <= S_DSET; cnt <= min1(t_ds); end
        S_DSET:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!wait_act) begin
            if (!wr_q) rsp_rdata <= fl[0] ? mem_dq_in : {8'h00, mem_dq_in[7:0]};
            if (t_dh != '0) begin st <= S_DHLD; cnt <= t_dh - 1'b1; end
            else begin st <= fin_st; cnt <= fin_cnt; rsp_valid <= 1'b1; end
          end
        S_DHLD:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin st <= fin_st; cnt <= fin_cnt; rsp_valid <= 1'b1; end
        S_TURN:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire act     = st inside {S_ADDR, S_AHLD, S_DSET, S_DHLD};
  wire lanes   = act || (st == S_BLS);
  wire addr_ph = fl[1] && (st inside {S_ADDR, S_AHLD});

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign mem_cs_n[i] = !(act && cs_q == CSW'(i));
  end

  assign req_ready  = idle;
  assign mem_addr   = addr_q;
  assign mem_oe_n   = !(st == S_DSET && !wr_q);
  assign mem_we_n   = !(st == S_DSET && wr_q);
  assign mem_be_n   = lanes ? (fl[0] ? ~be_q : 2'b10) : 2'b11;
  assign mem_dq_oe  = addr_ph || (wr_q && (st inside {S_DSET, S_DHLD}));
  assign mem_dq_out = addr_ph ? addr_q[15:0] : (fl[0] ? wd_q : {8'h00, wd_q[7:0]});

endmodule

// File: rtl/static_mem_ctrl_chk.sv
module static_mem_ctrl_chk #(
  parameter int NCS = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCS-1:0] mem_cs_n,
  input logic           mem_oe_n,
  input logic           mem_we_n,
  input logic [1:0]     mem_be_n,
  input logic           mem_dq_oe,
  input logic           rsp_valid,
  input logic           req_ready
);
  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~mem_cs_n)); // R2
  AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (&mem_cs_n)); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!mem_oe_n && !mem_we_n)); // R5
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n) (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n)); // R5
  AST_LANES_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n) !(&mem_cs_n) |-> (mem_be_n != 2'b11)); // R3
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R7
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) !mem_oe_n |-> !mem_dq_oe); // R12
  AST_RSP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rsp_valid) |-> (&mem_cs_n)); // R7
endmodule

bind static_mem_ctrl static_mem_ctrl_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_oe(mem_dq_oe),
  .rsp_valid(rsp_valid), .req_ready(req_ready)
);

// File: tb/test_static_mem_ctrl.sv
`timescale 1ns/1ps
module test_static_mem_ctrl;
  localparam int NCS = 2, AW = 20, TW = 4, CSW = 1, TSW = 5 * TW;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [CSW-1:0] req_cs = '0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = 2'b11;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [NCS*TSW-1:0] cfg_rd_tim, cfg_wr_tim;
  logic [NCS*TW-1:0] cfg_bls;
  logic [NCS*5-1:0] cfg_flags;
  logic [AW-1:0] mem_addr;
  logic [NCS-1:0] mem_cs_n;
  logic mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0] mem_be_n;
  logic [15:0] mem_dq_out, mem_dq_in;
  logic mem_wait = 0;

  int rd_t [NCS][5];
  int wr_t [NCS][5];
  int bls_c [NCS];
  bit wide [NCS], mux [NCS], wen [NCS], whi [NCS], sep [NCS];

  // R11: configuration packing
  always_comb begin
    for (int c = 0; c < NCS; c++) begin
      for (int f = 0; f < 5; f++) begin
        cfg_rd_tim[c*TSW + f*TW +: TW] = TW'(rd_t[c][f]);
        cfg_wr_tim[c*TSW + f*TW +: TW] = TW'(wr_t[c][f]);
      end
      cfg_bls[c*TW +: TW] = TW'(bls_c[c]);
      cfg_flags[c*5 +: 5] = {sep[c], whi[c], wen[c], mux[c], wide[c]};
    end
  end

  assign mem_dq_in = mem_addr[15:0] ^ 16'h5A3C;

  static_mem_ctrl #(.NCS(NCS), .AW(AW), .TW(TW)) i_static_mem_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_rd_tim(cfg_rd_tim), .cfg_wr_tim(cfg_wr_tim), .cfg_bls(cfg_bls), .cfg_flags(cfg_flags),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .mem_wait(mem_wait)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // phases: 0 idle,1 bls,2 addr,3 ahold,4 dset,5 dhold,6 turn
  task automatic txn(input int cs, input bit wr, input logic [AW-1:0] addr,
                     input logic [15:0] wd, input logic [1:0] be, input int wcyc);
    int t[5];
    int B, A, H, D, DH, T, E, ph;
    bit wlvl;
    string tag;
    logic [1:0] ebe;
    logic [15:0] eval;
    for (int f = 0; f < 5; f++) t[f] = (wr && sep[cs]) ? wr_t[cs][f] : rd_t[cs][f];
    B  = bls_c[cs];
    A  = mx(t[0], 1);
    H  = mux[cs] ? t[1] : 0;
    D  = wen[cs] ? mx(mx(t[2], 1), wcyc + 1) : mx(t[2], 1);
    DH = t[3];
    T  = t[4];
    E  = B + A + H + D + DH;
    ebe = wide[cs] ? ~be : 2'b10;
    chk(req_ready === 1'b1, "R2 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1; req_write = wr; req_cs = CSW'(cs); req_addr = addr; req_wdata = wd; req_be = be;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k <= E + T; k++) begin
      if (k < B) ph = 1;
      else if (k < B + A) ph = 2;
      else if (k < B + A + H) ph = 3;
      else if (k < B + A + H + D) ph = 4;
      else if (k < E) ph = 5;
      else if (k < E + T) ph = 6;
      else ph = 0;
      wlvl = (ph == 4 && (k - (B + A + H)) < wcyc) ? whi[cs] : !whi[cs];
      mem_wait = wlvl;
      case (ph)
        1: tag = "R3"; 2: tag = "R4"; 3: tag = "R4"; 4: tag = (wcyc > 0) ? "R10" : "R5";
        5: tag = "R6"; default: tag = "R8";
      endcase
      if (wr && sep[cs] && ph != 0) tag = {tag, "/R9"};
      begin
        logic [NCS-1:0] ecs;
        logic eoe, ewe, eact;
        logic [1:0] eb;
        eact = (ph >= 2 && ph <= 5);
        ecs = eact ? ~(NCS'(1) << cs) : '1;
        eoe = !(ph == 4 && !wr);
        ewe = !(ph == 4 && wr);
        eb  = (ph >= 1 && ph <= 5) ? ebe : 2'b11;
        chk({mem_cs_n, mem_oe_n, mem_we_n, mem_be_n} === {ecs, eoe, ewe, eb}, tag,
            32'({mem_cs_n, mem_oe_n, mem_we_n, mem_be_n}), 32'({ecs, eoe, ewe, eb}));
        chk(mem_dq_oe === ((mux[cs] && (ph == 2 || ph == 3)) || (wr && (ph == 4 || ph == 5))),
            wr ? "R5 dq drive" : "R12 dq drive", {31'd0, mem_dq_oe}, 32'hx);
        if (mem_dq_oe === 1'b1) begin
          eval = (ph == 2 || ph == 3) ? addr[15:0] : (wide[cs] ? wd : {8'h00, wd[7:0]});
          chk(mem_dq_out === eval, (ph == 2 || ph == 3) ? "R4 mux addr" : "R5 wdata",
              {16'd0, mem_dq_out}, {16'd0, eval});
        end
        if (eact) chk(mem_addr === addr, "R2 address", 32'(mem_addr), 32'(addr));
        chk(rsp_valid === (k == E), "R7 rsp_valid", {31'd0, rsp_valid}, {31'd0, k == E});
        if (k == E && !wr) begin
          eval = addr[15:0] ^ 16'h5A3C;
          if (!wide[cs]) eval[15:8] = 8'h00;
          chk(rsp_rdata === eval, "R7 rdata", {16'd0, rsp_rdata}, {16'd0, eval});
        end
        chk(req_ready === (ph == 0), (k >= E) ? "R8 ready" : "R2 ready",
            {31'd0, req_ready}, {31'd0, ph == 0});
      end
      if (k < E + T) @(negedge clk);
    end
    mem_wait = !whi[cs];
  endtask

  task automatic set_cs(input int cs, input int a0, input int a1, input int a2, input int a3, input int a4,
                        input int b, input bit w, input bit m, input bit we, input bit wh, input bit s);
    rd_t[cs] = '{a0, a1, a2, a3, a4};
    bls_c[cs] = b; wide[cs] = w; mux[cs] = m; wen[cs] = we; whi[cs] = wh; sep[cs] = s;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < NCS; c++) begin
      set_cs(c, 1, 0, 1, 0, 0, 0, 1, 0, 0, 0, 0);
      wr_t[c] = '{0, 0, 1, 0, 0};
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({mem_cs_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe, req_ready, rsp_valid} ===
        {{NCS{1'b1}}, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0}, "R1 reset",
        32'({mem_cs_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe, req_ready, rsp_valid}),
        32'({{NCS{1'b1}}, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0}));
    rst_n = 1;
    @(negedge clk);
    // R3 R4 R5 R6 R8 plain read and write
    set_cs(0, 2, 3, 3, 1, 2, 1, 1, 0, 0, 0, 0);
    txn(0, 0, 20'h01234, 16'h0, 2'b11, 0);
    txn(0, 1, 20'h0ABCD, 16'hBEEF, 2'b01, 0);
    // all zero counts
    set_cs(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    txn(1, 0, 20'h00010, 16'h0, 2'b11, 0);
    txn(1, 1, 20'h00011, 16'h1234, 2'b10, 0);
    // R4 multiplexed with and without hold
    set_cs(0, 1, 2, 2, 1, 1, 0, 1, 1, 0, 0, 0);
    txn(0, 0, 20'hF0F0F, 16'h0, 2'b11, 0);
    txn(0, 1, 20'h13579, 16'hCAFE, 2'b11, 0);
    set_cs(0, 1, 0, 1, 0, 0, 2, 1, 1, 0, 0, 0);
    txn(0, 0, 20'h02468, 16'h0, 2'b11, 0);
    // narrow device
    set_cs(1, 2, 0, 2, 2, 1, 1, 0, 0, 0, 0, 0);
    txn(1, 1, 20'h00FF0, 16'hA55A, 2'b11, 0);
    txn(1, 0, 20'h00FF1, 16'h0, 2'b11, 0);
    // R9 separate write set vs primary
    set_cs(0, 1, 0, 1, 0, 0, 0, 1, 0, 0, 0, 1);
    wr_t[0] = '{3, 1, 4, 2, 3};
    txn(0, 1, 20'h0AAAA, 16'h5555, 2'b11, 0);
    txn(0, 0, 20'h0AAAB, 16'h0, 2'b11, 0);
    sep[0] = 0;
    txn(0, 1, 20'h0AAAC, 16'h6666, 2'b11, 0);
    // R10 wait active low, active high, disabled
    set_cs(1, 1, 0, 1, 1, 0, 0, 1, 0, 1, 0, 0);
    mem_wait = 1;
    txn(1, 0, 20'h00300, 16'h0, 2'b11, 3);
    whi[1] = 1; mem_wait = 0;
    txn(1, 1, 20'h00301, 16'h7777, 2'b11, 4);
    wen[1] = 0;
    txn(1, 0, 20'h00302, 16'h0, 2'b11, 5);
    // random
    for (int n = 0; n < 80; n++) begin
      int c;
      c = $urandom_range(0, NCS - 1);
      set_cs(c, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 4),
             $urandom_range(0, 2), $urandom_range(0, 3), $urandom_range(0, 2),
             1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      for (int f = 0; f < 5; f++) wr_t[c][f] = $urandom_range(0, 3);
      mem_wait = !whi[c];
      @(negedge clk);
      txn(c, 1'($urandom), AW'($urandom), 16'($urandom), 2'($urandom_range(1, 3)),
          $urandom_range(0, 4));
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule